// File: doc/BRIEF.md
# Power-up recall sequencer

This block decides what a mixed-signal device is allowed to do while its supply ramps up, sags or collapses. It reads two asynchronous supply-level indicators. One says the supply is above the lower, digital threshold. The other says it is above the higher, analog threshold. Both pass through two-flop synchronizers. From the synchronized levels the block enables the serial interface. Once the analog level is good, it copies the non-volatile settings into shadow registers. It also drives an active-low ready status bit that the converter logic uses as its run permission.

The recall reads a non-volatile port that has a fixed read latency. It issues one address per cycle, writes each returned word into the shadow store in address order, and pulses a completion strobe together with the last write. Recalled values stay valid through an analog-level dip. Only a loss of the digital level discards them and forces a fresh recall.

While the recall is incomplete, the block overrides two things. The main device address falls back to A2h. The auxiliary address A0h answers whatever its enable says. A low-supply alarm flag powers up set and holds until the first conversion that finishes while the ready bit is low.

Top module: `pwrup_recall_seq`

## Requirements
- R1: While the synchronized digital level is low, `serial_en` is 0, `shadow_valid` is 0, `ready_n` is 1 and no non-volatile read is issued.
- R2: A non-volatile read (`nvm_rd_en` = 1) is only issued while the shadow store is invalid and the analog level has been high within the preceding few cycles.
- R3: A recall reads addresses 0 to NUM_REGS-1 on consecutive cycles. Each word is written to the shadow store RD_LAT cycles after its read, at the same address and in ascending order. `recall_done` pulses together with the write of address NUM_REGS-1.
- R4: `ready_n` is 1 from reset. It goes to 0 in the cycle `shadow_valid` becomes 1, which is 3 + NUM_REGS + RD_LAT clock edges after the analog indicator rises, provided the digital indicator was already settled high. `ready_n` is never 0 while `shadow_valid` is 0.
- R5: When the analog indicator falls after a completed recall, `ready_n` reads 1 from the third clock edge on. `shadow_valid` stays 1. When the analog level returns, `ready_n` goes back to 0 without any new read.
- R6: A loss of the digital level clears `shadow_valid`. The next rise of both levels runs a complete new recall.
- R7: `main_dev_addr` is A2h while `shadow_valid` is 0 or `addr_from_nvm` is 0. Otherwise it is `nvm_main_addr`.
- R8: `aux_dev_answer` is 1 whenever `serial_en` is 1 and `shadow_valid` is 0, regardless of `aux_enable`. After the recall it follows `aux_enable`.
- R9: `low_supply_flag` is 1 from reset and whenever the digital level is lost. A `conv_done` pulse loads it with `conv_low_supply` only in a cycle where `ready_n` is 0. Otherwise it holds.
- R10: If the analog level is lost before the recall completes, the recall is abandoned without a completion strobe. It later restarts from address 0.
- R11: Both indicators pass through two flops: `serial_en` rises on the third clock edge after the digital indicator rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vdig_ok_async | input | 1 | Supply above digital threshold, unsynchronized |
| vana_ok_async | input | 1 | Supply above analog threshold, unsynchronized |
| nvm_rd_en | output | 1 | Non-volatile read request |
| nvm_rd_addr | output | ADDR_W | Non-volatile read address |
| nvm_rd_data | input | DATA_W | Read data, valid RD_LAT cycles after the request |
| shd_wr_en | output | 1 | Shadow register write strobe |
| shd_wr_addr | output | ADDR_W | Shadow register write address |
| shd_wr_data | output | DATA_W | Shadow register write data |
| recall_done | output | 1 | One-cycle strobe on the final recall write |
| shadow_valid | output | 1 | Shadow store holds recalled values |
| serial_en | output | 1 | Serial interface enabled |
| ready_n | output | 1 | Ready status bit, 0 = ready and converting |
| conv_done | input | 1 | A conversion finished this cycle |
| conv_low_supply | input | 1 | Low-supply result of that conversion |
| low_supply_flag | output | 1 | Low-supply alarm flag |
| addr_from_nvm | input | 1 | Main address taken from the recalled setting |
| nvm_main_addr | input | 8 | Recalled main device address |
| aux_enable | input | 1 | Recalled auxiliary address enable |
| main_dev_addr | output | 8 | Effective main device address |
| aux_dev_answer | output | 1 | Auxiliary address A0h answers |

## Verification
The delicate coincidence is a conversion completing on the same edge at which an analog drop turns the ready bit back to 1. The flag must be loaded because the decision is taken on the ready value before that edge. The bench provokes this by raising `conv_done` with random low-supply results in most cycles while it toggles the supply indicators at random. It judges the flag every cycle with a model driven only by the `ready_n` and `conv_done` values it sampled in the previous cycle. A second coincidence, the last recall write landing as the analog level falls, is covered by the same random toggling. There the completed recall must win: `shadow_valid` is set and the write sequence is not reported as abandoned.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    PS_OFF      = 2'd0,
    PS_WAIT_ANA = 2'd1,
    PS_RECALL   = 2'd2,
    PS_VALID    = 2'd3
  } pwr_state_e;

  localparam logic [7:0] MAIN_ADDR_FALLBACK = 8'hA2;
  localparam logic [7:0] AUX_ADDR           = 8'hA0;

endpackage

// File: rtl/psq_sync.sv
module psq_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q, stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/psq_recall_walker.sv
module psq_recall_walker #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8,
  parameter int RD_LAT   = 2,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              done
);

  localparam int CNT_W = $clog2(NUM_REGS + 1);
  localparam logic [CNT_W-1:0]  CNT_END   = CNT_W'(NUM_REGS);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

  logic [CNT_W-1:0]                iss_q, iss_d;
  logic [RD_LAT-1:0]               vld_q, vld_d;
  logic [RD_LAT-1:0][ADDR_W-1:0]   adr_q, adr_d;

  assign rd_en   = active && (iss_q < CNT_END);
  assign rd_addr = iss_q[ADDR_W-1:0];

  always_comb begin
    iss_d = '0;
    if (active) begin
      iss_d = rd_en ? iss_q + 1'b1 : iss_q;
    end
  end

  always_comb begin
    vld_d = '0;
    adr_d = adr_q;
    if (active) begin
      vld_d[0] = rd_en;
      adr_d[0] = rd_addr;
      for (int i = 1; i < RD_LAT; i++) begin
        vld_d[i] = vld_q[i-1];
        adr_d[i] = adr_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_q <= '0;
      vld_q <= '0;
      adr_q <= '0;
    end else begin
      iss_q <= iss_d;
      vld_q <= vld_d;
      adr_q <= adr_d;
    end
  end

  assign wr_en   = active && vld_q[RD_LAT-1];
  assign wr_addr = adr_q[RD_LAT-1];
  assign wr_data = rd_data;
  assign done    = wr_en && (wr_addr == LAST_ADDR);

  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1)); // R3

  AST_FIRST_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !$past(active)) |-> (rd_addr == '0)); // R10

endmodule

// File: rtl/psq_status.sv
module psq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic off_d,
  input  logic valid_d,
  input  logic vana_s,
  input  logic conv_done,
  input  logic conv_low_supply,
  output logic ready_n,
  output logic low_supply_flag
);

  logic rdy_n_q, rdy_n_d;
  logic flag_q, flag_d;

  always_comb begin
    rdy_n_d = !(valid_d && vana_s);
  end

  always_comb begin
    flag_d = flag_q;
    if (off_d) begin
      flag_d = 1'b1;
    end else if (!rdy_n_q && conv_done) begin
      flag_d = conv_low_supply;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_n_q <= 1'b1;
      flag_q  <= 1'b1;
    end else begin
      rdy_n_q <= rdy_n_d;
      flag_q  <= flag_d;
    end
  end

  assign ready_n         = rdy_n_q;
  assign low_supply_flag = flag_q;

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_n && !off_d) |=> $stable(low_supply_flag)); // R9

  AST_OFF_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    off_d |=> (ready_n && low_supply_flag)); // R1

endmodule

// File: rtl/psq_addr_sel.sv
module psq_addr_sel
  import pwr_seq_pkg::*;
(
  input  logic       serial_en,
  input  logic       shadow_valid,
  input  logic       addr_from_nvm,
  input  logic [7:0] nvm_main_addr,
  input  logic       aux_enable,
  output logic [7:0] main_dev_addr,
  output logic       aux_dev_answer
);

  always_comb begin
    main_dev_addr = MAIN_ADDR_FALLBACK;
    if (shadow_valid && addr_from_nvm) begin
      main_dev_addr = nvm_main_addr;
    end
  end

  always_comb begin
    aux_dev_answer = serial_en && (aux_enable || !shadow_valid);
  end

endmodule

// File: rtl/pwrup_recall_seq.sv
module pwrup_recall_seq
  import pwr_seq_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int DATA_W      = 8,
  parameter int RD_LAT      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vdig_ok_async,
  input  logic              vana_ok_async,
  output logic              nvm_rd_en,
  output logic [ADDR_W-1:0] nvm_rd_addr,
  input  logic [DATA_W-1:0] nvm_rd_data,
  output logic              shd_wr_en,
  output logic [ADDR_W-1:0] shd_wr_addr,
  output logic [DATA_W-1:0] shd_wr_data,
  output logic              recall_done,
  output logic              shadow_valid,
  output logic              serial_en,
  output logic              ready_n,
  input  logic              conv_done,
  input  logic              conv_low_supply,
  output logic              low_supply_flag,
  input  logic              addr_from_nvm,
  input  logic [7:0]        nvm_main_addr,
  input  logic              aux_enable,
  output logic [7:0]        main_dev_addr,
  output logic              aux_dev_answer
);

  logic [1:0] lvl_s;
  logic       vdig_s, vana_s;
  pwr_state_e state_q, state_d;
  logic       rc_active, rc_done;

  psq_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({vdig_ok_async, vana_ok_async}),
    .q     (lvl_s)
  );

  assign vdig_s = lvl_s[1];
  assign vana_s = lvl_s[0];

  always_comb begin
    state_d = state_q;
    if (!vdig_s) begin
      state_d = PS_OFF;
    end else begin
      case (state_q)
        PS_OFF:      state_d = PS_WAIT_ANA;
        PS_WAIT_ANA: if (vana_s) state_d = PS_RECALL;
        PS_RECALL: begin
          if (rc_done)      state_d = PS_VALID;
          else if (!vana_s) state_d = PS_WAIT_ANA;
        end
        PS_VALID:    state_d = PS_VALID;
        default:     state_d = PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_OFF;
    end else begin
      state_q <= state_d;
    end
  end

  assign rc_active    = (state_q == PS_RECALL);
  assign shadow_valid = (state_q == PS_VALID);
  assign serial_en    = (state_q != PS_OFF);

  psq_recall_walker #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .RD_LAT   (RD_LAT),
    .ADDR_W   (ADDR_W)
  ) i_walker (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (rc_active),
    .rd_en   (nvm_rd_en),
    .rd_addr (nvm_rd_addr),
    .rd_data (nvm_rd_data),
    .wr_en   (shd_wr_en),
    .wr_addr (shd_wr_addr),
    .wr_data (shd_wr_data),
    .done    (rc_done)
  );

  assign recall_done = rc_done;

  psq_status i_status (
    .clk             (clk),
    .rst_n           (rst_n),
    .off_d           (state_d == PS_OFF),
    .valid_d         (state_d == PS_VALID),
    .vana_s          (vana_s),
    .conv_done       (conv_done),
    .conv_low_supply (conv_low_supply),
    .ready_n         (ready_n),
    .low_supply_flag (low_supply_flag)
  );

  psq_addr_sel i_addr_sel (
    .serial_en      (serial_en),
    .shadow_valid   (shadow_valid),
    .addr_from_nvm  (addr_from_nvm),
    .nvm_main_addr  (nvm_main_addr),
    .aux_enable     (aux_enable),
    .main_dev_addr  (main_dev_addr),
    .aux_dev_answer (aux_dev_answer)
  );

  AST_READ_NEEDS_ANALOG: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_rd_en |-> (vana_s || $past(vana_s))); // R2

  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_n |-> shadow_valid); // R4

  AST_DIG_LOSS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !vdig_s |=> (!shadow_valid && !serial_en)); // R6

  AST_DONE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (recall_done && vdig_s) |=> shadow_valid); // R3

  AST_ABORT_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_active && !vana_s && !recall_done) |=> !shadow_valid); // R10

  AST_VALID_KEPT_ON_ANA_DIP: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_valid && vdig_s) |=> shadow_valid); // R5

  AST_FALLBACK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !shadow_valid |-> (main_dev_addr == MAIN_ADDR_FALLBACK)); // R7

  AST_AUX_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (serial_en && !shadow_valid) |-> aux_dev_answer); // R8

endmodule

// File: tb/test_pwrup_recall_seq.sv
module test_pwrup_recall_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_REGS   = 16;
  localparam int DATA_W     = 8;
  localparam int RD_LAT     = 2;
  localparam int ADDR_W     = $clog2(NUM_REGS);
  localparam int REC_EDGES  = 3 + NUM_REGS + RD_LAT;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              vdig_ok_async, vana_ok_async;
  logic              nvm_rd_en;
  logic [ADDR_W-1:0] nvm_rd_addr;
  logic [DATA_W-1:0] nvm_rd_data;
  logic              shd_wr_en;
  logic [ADDR_W-1:0] shd_wr_addr;
  logic [DATA_W-1:0] shd_wr_data;
  logic              recall_done, shadow_valid, serial_en, ready_n;
  logic              conv_done, conv_low_supply, low_supply_flag;
  logic              addr_from_nvm, aux_enable, aux_dev_answer;
  logic [7:0]        nvm_main_addr, main_dev_addr;

  int n_chk = 0;
  int n_bad = 0;
  int done_cnt = 0;
  int rd_cnt = 0;
  int exp_idx = 0;
  bit mon_en = 1'b0;
  bit finished = 1'b0;
  logic exp_flag = 1'b1;
  logic p_ready_n = 1'b1;
  logic p_conv = 1'b0;
  logic p_low = 1'b0;
  logic [3:0] vana_hist = '0;
  logic [RD_LAT-1:0]             bp_vld;
  logic [RD_LAT-1:0][ADDR_W-1:0] bp_adr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrup_recall_seq #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .RD_LAT(RD_LAT)
  ) i_pwrup_recall_seq (
    .clk(clk), .rst_n(rst_n),
    .vdig_ok_async(vdig_ok_async), .vana_ok_async(vana_ok_async),
    .nvm_rd_en(nvm_rd_en), .nvm_rd_addr(nvm_rd_addr), .nvm_rd_data(nvm_rd_data),
    .shd_wr_en(shd_wr_en), .shd_wr_addr(shd_wr_addr), .shd_wr_data(shd_wr_data),
    .recall_done(recall_done), .shadow_valid(shadow_valid), .serial_en(serial_en),
    .ready_n(ready_n), .conv_done(conv_done), .conv_low_supply(conv_low_supply),
    .low_supply_flag(low_supply_flag), .addr_from_nvm(addr_from_nvm),
    .nvm_main_addr(nvm_main_addr), .aux_enable(aux_enable),
    .main_dev_addr(main_dev_addr), .aux_dev_answer(aux_dev_answer)
  );

  function automatic logic [DATA_W-1:0] mem_f(input int a);
    return DATA_W'((a * 29 + 60) ^ 165);
  endfunction

  // memory model with fixed read latency
  always @(posedge clk) begin
    bp_vld <= {bp_vld[RD_LAT-2:0], nvm_rd_en};
    bp_adr <= {bp_adr[RD_LAT-2:0], nvm_rd_addr};
  end
  assign nvm_rd_data = mem_f(int'(bp_adr[RD_LAT-1]));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // continuous monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (mon_en) begin
      if (shd_wr_en) begin
        if (shd_wr_addr == '0) exp_idx = 0;
        chk(int'(shd_wr_addr) == exp_idx, "R3 write order", int'(shd_wr_addr), exp_idx);
        chk(shd_wr_data == mem_f(int'(shd_wr_addr)), "R3 write data",
            int'(shd_wr_data), int'(mem_f(int'(shd_wr_addr))));
        exp_idx++;
      end
      if (recall_done) begin
        done_cnt++;
        chk(exp_idx == NUM_REGS, "R3 done on last write", exp_idx, NUM_REGS);
      end
      if (nvm_rd_en) begin
        rd_cnt++;
        chk(serial_en && !shadow_valid && (vana_hist != 4'b0), "R2 read gating",
            int'({serial_en, shadow_valid}), 2);
      end
      if (!ready_n) chk(shadow_valid, "R4 ready implies valid", int'(shadow_valid), 1);
      if (!serial_en)
        chk(!shadow_valid && ready_n && low_supply_flag, "R1 inactive below digital",
            int'({shadow_valid, ready_n, low_supply_flag}), 3);
      if (!shadow_valid || !addr_from_nvm)
        chk(main_dev_addr == 8'hA2, "R7 fallback address", int'(main_dev_addr), 8'hA2);
      if (serial_en && !shadow_valid)
        chk(aux_dev_answer, "R8 aux open during power-up", int'(aux_dev_answer), 1);
      if (!serial_en) exp_flag = 1'b1;
      else if (!p_ready_n && p_conv) exp_flag = p_low;
      chk(low_supply_flag == exp_flag, "R9 flag model", int'(low_supply_flag), int'(exp_flag));
      p_ready_n = ready_n;
      p_conv    = conv_done;
      p_low     = conv_low_supply;
      vana_hist = {vana_hist[2:0], vana_ok_async};
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int d0, r0;
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    vdig_ok_async = 1'b0; vana_ok_async = 1'b0;
    conv_done = 1'b0; conv_low_supply = 1'b0;
    addr_from_nvm = 1'b1; nvm_main_addr = 8'h5C; aux_enable = 1'b0;
    tick(3);
    @(negedge clk);
    chk(serial_en == 1'b0, "R1 reset serial", int'(serial_en), 0);
    chk(ready_n == 1'b1, "R4 reset ready", int'(ready_n), 1);
    chk(low_supply_flag == 1'b1, "R9 reset flag", int'(low_supply_flag), 1);
    chk(main_dev_addr == 8'hA2, "R7 reset addr", int'(main_dev_addr), 8'hA2);
    @(posedge clk); #1;
    rst_n = 1'b1;
    mon_en = 1'b1;
    tick(2);

    // digital level rises: interface on at third edge
    vdig_ok_async = 1'b1;
    repeat (3) @(negedge clk);
    chk(serial_en == 1'b0, "R11 serial still off after 2 edges", int'(serial_en), 0);
    @(negedge clk);
    chk(serial_en == 1'b1, "R11 serial on after 3 edges", int'(serial_en), 1);
    chk(aux_dev_answer == 1'b1, "R8 aux answers pre-recall", int'(aux_dev_answer), 1);
    tick(10);
    chk(rd_cnt == 0, "R2 no recall without analog", rd_cnt, 0);

    // analog level rises: recall and ready timing
    vana_ok_async = 1'b1;
    repeat (REC_EDGES) @(negedge clk);
    chk(ready_n == 1'b1, "R4 not ready one edge early", int'(ready_n), 1);
    @(negedge clk);
    chk(ready_n == 1'b0, "R4 ready after recall", int'(ready_n), 0);
    chk(shadow_valid == 1'b1, "R3 shadow valid", int'(shadow_valid), 1);
    chk(done_cnt == 1, "R3 one completion", done_cnt, 1);
    chk(rd_cnt == NUM_REGS, "R3 read count", rd_cnt, NUM_REGS);
    chk(main_dev_addr == 8'h5C, "R7 recalled address", int'(main_dev_addr), 8'h5C);
    chk(aux_dev_answer == 1'b0, "R8 aux follows enable", int'(aux_dev_answer), 0);
    @(posedge clk); #1;

    // first conversion clears the alarm
    conv_done = 1'b1; conv_low_supply = 1'b0;
    tick(1);
    conv_done = 1'b0;
    @(negedge clk);
    chk(low_supply_flag == 1'b0, "R9 first conversion updates flag", int'(low_supply_flag), 0);
    @(posedge clk); #1;

    // analog dip after recall
    vana_ok_async = 1'b0;
    repeat (3) @(negedge clk);
    chk(ready_n == 1'b0, "R5 ready holds 2 edges", int'(ready_n), 0);
    @(negedge clk);
    chk(ready_n == 1'b1, "R5 ready rises on analog loss", int'(ready_n), 1);
    chk(shadow_valid == 1'b1, "R5 shadow kept", int'(shadow_valid), 1);
    @(posedge clk); #1;
    conv_done = 1'b1; conv_low_supply = 1'b1;
    tick(1);
    conv_done = 1'b0;
    @(negedge clk);
    chk(low_supply_flag == 1'b0, "R9 conversion ignored while not ready", int'(low_supply_flag), 0);
    @(posedge clk); #1;
    r0 = rd_cnt;
    vana_ok_async = 1'b1;
    tick(6);
    chk(ready_n == 1'b0, "R5 ready back without recall", int'(ready_n), 0);
    chk(rd_cnt == r0, "R5 no new reads", rd_cnt, r0);

    // digital loss forces a fresh recall
    vdig_ok_async = 1'b0; vana_ok_async = 1'b0;
    tick(5);
    chk(shadow_valid == 1'b0, "R6 shadow dropped", int'(shadow_valid), 0);
    chk(low_supply_flag == 1'b1, "R9 flag set on digital loss", int'(low_supply_flag), 1);
    vdig_ok_async = 1'b1; vana_ok_async = 1'b1;
    tick(REC_EDGES + 4);
    chk(done_cnt == 2, "R6 second full recall", done_cnt, 2);
    chk(shadow_valid == 1'b1, "R6 valid again", int'(shadow_valid), 1);

    // abort mid-recall on analog loss
    vdig_ok_async = 1'b0; vana_ok_async = 1'b0;
    tick(5);
    vdig_ok_async = 1'b1; vana_ok_async = 1'b1;
    tick(3 + NUM_REGS / 2);
    d0 = done_cnt;
    vana_ok_async = 1'b0;
    tick(NUM_REGS + 8);
    chk(done_cnt == d0, "R10 no completion after abort", done_cnt, d0);
    chk(shadow_valid == 1'b0, "R10 shadow invalid after abort", int'(shadow_valid), 0);
    vana_ok_async = 1'b1;
    tick(REC_EDGES + 4);
    chk(done_cnt == d0 + 1, "R10 restarted recall completes", done_cnt, d0 + 1);

    // constrained random supply activity with busy converter
    for (int it = 0; it < 300; it++) begin
      int sel, hold;
      sel  = int'($urandom % 4);
      hold = 1 + int'($urandom % 40);
      vdig_ok_async = (sel != 0);
      vana_ok_async = (sel >= 2);
      aux_enable    = $urandom % 2;
      addr_from_nvm = $urandom % 2;
      nvm_main_addr = 8'($urandom);
      for (int c = 0; c < hold; c++) begin
        conv_done       = ($urandom % 3) != 0;
        conv_low_supply = $urandom % 2;
        tick(1);
      end
    end
    conv_done = 1'b0;
    tick(4);
    summary();
  end

endmodule